// File: doc/BRIEF.md
# Display Command Descriptor Transmitter

This block takes 32-bit words from a small transmit FIFO and sends them to a display over a four-wire serial link: serial clock, serial data, an active-low select and a data/command line. Software, or any other producer, writes a descriptor word first and then the payload packed four bytes per word. The descriptor gives the byte count, whether the bytes are command or pixel data, the unit size used for optional byte swapping, whether to report completion, and whether to hold the transfer until an edge on the panel's tearing-effect input.

When gating on tearing effect is requested, the engine waits for the chosen edge and then for a delay counted in slow timer ticks. A tick is `te_delay` units of 2^(`ratio0`+`ratio1`) core clocks. The serial clock runs at half the core clock. It idles low, data changes while it is low and is meant to be sampled on its rising edge. If payload is not yet in the FIFO, the engine stalls with select held active. The FIFO reports a level-below-threshold flag and a sticky overflow flag. Dropping the enable flushes everything and returns the engine to idle.

Top module: `dcmd_tx`

## Requirements
- R1: A descriptor word carries the byte count minus one in bits [17:0]. Exactly that count plus one bytes are shifted out, with `cs_n` low from the descriptor pop until the last bit, after which `cs_n` returns high.
- R2: Descriptor bit 30 selects command (0) or data (1). `dc` shows that value for every byte of the transaction and does not change while `cs_n` stays low.
- R3: `sclk` is low whenever `cs_n` is high. Each bit is held on `sdo` across one low and one high phase of `sclk`. Bits go most significant first when `lsb_first` is 0 and least significant first when it is 1.
- R4: Payload byte j of each word (j = 0..3) comes from bits [8j+7:8j], so the earliest byte sits in the lowest lane. A final partial word uses only its low lanes, and its unused lanes are discarded.
- R5: Descriptor bits [28:27] select the swap unit: 0 = one byte, 1 = two bytes, 2 = four bytes, 3 = one byte. With `swap_en` high, byte j of a word is taken from lane j XOR (unit−1), which reverses the order inside each unit.
- R6: Descriptor bits [25:24] select the tearing-effect gate: 0 or 3 = none, 1 = wait for a rising edge on `te_in`, 2 = wait for a falling edge. No bit is sent before the chosen edge, and an edge of the other polarity is ignored.
- R7: After the tearing edge, the first `sclk` rise comes no earlier than `te_delay`·2^(`ratio0`+`ratio1`) core clocks after `te_in` changes, and no more than 12 clocks later than that.
- R8: If descriptor bit 29 is set, `done` pulses high for one cycle when the last bit of the transaction finishes, and `cs_n` is already high in that cycle. If the bit is clear, `done` stays low.
- R9: A write while the FIFO holds `FIFO_DEPTH` words is dropped and sets `fifo_ovf`. The flag stays set until `enable` drops.
- R10: `fifo_low` is high exactly when the FIFO level is at or below `thresh`.
- R11: While `enable` is low, the FIFO is empty, writes are ignored, `fifo_ovf` is clear and the engine is idle with `cs_n` high. On re-enable, no earlier word is sent.
- R12: If the next payload word has not yet arrived, the engine waits with `cs_n` low and `sclk` low. It resumes when the word is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Block enable; low flushes and idles |
| lsb_first | input | 1 | Serial bit order select |
| swap_en | input | 1 | Enable byte swap within the descriptor's unit |
| thresh | input | LVL_W | FIFO level threshold for `fifo_low` |
| te_delay | input | DLY_W | Delay after the tearing edge, in slow ticks |
| ratio0 | input | RAT_W | First prescale exponent |
| ratio1 | input | RAT_W | Second prescale exponent |
| te_in | input | 1 | Tearing-effect input from the panel (asynchronous) |
| wr_valid | input | 1 | FIFO write strobe |
| wr_data | input | 32 | FIFO write word (descriptor or payload) |
| sclk | output | 1 | Serial clock |
| sdo | output | 1 | Serial data |
| cs_n | output | 1 | Active-low select |
| dc | output | 1 | Data/command line, 1 = data |
| done | output | 1 | One-cycle completion pulse |
| fifo_low | output | 1 | FIFO level at or below threshold |
| fifo_ovf | output | 1 | Sticky overflow flag |

## Verification
Random transfers with lengths from 1 to 64 bytes mix every swap unit, both bit orders, both command/data settings and done enabled or not. Lengths that do not fill the last word separate correct lane selection from over-reading of stale lanes. Directed cases hold back the tearing edge, first with the wrong polarity and then with the right one, so a gate that fires on any edge is told apart from one that fires on the chosen edge. A timed edge checks the delay window. Other directed cases starve the FIFO in mid-transfer, fill it past capacity with the engine held off, and drop the enable with words queued. Together these show whether a stall, a dropped word or a flush corrupts what reaches the wire.

// File: rtl/dcmd_pkg.sv
package dcmd_pkg;

    localparam int LEN_W = 18;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_TE    = 2'd1,
        ST_LOAD  = 2'd2,
        ST_SHIFT = 2'd3
    } eng_st_e;

    typedef struct packed {
        logic [LEN_W-1:0] len_m1;
        logic [1:0]       te_mode;
        logic [1:0]       unit;
        logic             done_en;
        logic             is_data;
    } desc_t;

    typedef struct packed {
        eng_st_e     st;
        desc_t       desc;
        logic [31:0] word;
        logic [1:0]  lane;
        logic [7:0]  sh;
        logic [2:0]  bitc;
        logic        phase;
        logic        done;
    } eng_regs_t;

    // Field positions are fixed by the producer's encoding.
    function automatic desc_t desc_decode(input logic [31:0] w);
        desc_t d;
        d.len_m1  = w[LEN_W-1:0];
        d.te_mode = w[25:24];
        d.unit    = w[28:27];
        d.done_en = w[29];
        d.is_data = w[30];
        return d;
    endfunction

    function automatic logic [1:0] lane_mask(input logic [1:0] unit);
        case (unit)
            2'd1:    return 2'b01;
            2'd2:    return 2'b11;
            default: return 2'b00;
        endcase
    endfunction

endpackage

// File: rtl/dcmd_fifo.sv
module dcmd_fifo #(
    parameter int DEPTH = 8,
    parameter int W     = 32
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       flush,
    input  logic                       push,
    input  logic [W-1:0]               din,
    input  logic                       pop,
    output logic [W-1:0]               dout,
    output logic                       empty,
    output logic [$clog2(DEPTH):0]     level,
    output logic                       ovf
);
    localparam int AW = $clog2(DEPTH);
    localparam int LW = AW + 1;

    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] mem;
        logic [AW-1:0]           wp;
        logic [AW-1:0]           rp;
        logic [LW-1:0]           cnt;
        logic                    ovf;
    } fifo_regs_t;

    fifo_regs_t q, d;
    logic full, do_push, do_pop;

    always_comb begin
        d       = q;
        full    = (q.cnt == LW'(DEPTH));
        do_push = push && !full;
        do_pop  = pop && (q.cnt != '0);
        if (flush) begin
            d.wp  = '0;
            d.rp  = '0;
            d.cnt = '0;
            d.ovf = 1'b0;
        end else begin
            if (push && full) d.ovf = 1'b1;
            if (do_push) begin
                d.mem[q.wp] = din;
                d.wp = (q.wp == AW'(DEPTH-1)) ? '0 : q.wp + 1'b1;
            end
            if (do_pop) d.rp = (q.rp == AW'(DEPTH-1)) ? '0 : q.rp + 1'b1;
            d.cnt = q.cnt + LW'(do_push) - LW'(do_pop);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign dout  = q.mem[q.rp];
    assign empty = (q.cnt == '0);
    assign level = q.cnt;
    assign ovf   = q.ovf;

    assert_level_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
        q.cnt <= LW'(DEPTH));
    assert_ovf_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        q.ovf && !flush |=> q.ovf);
    assert_flush_empties_R11: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> empty && !ovf);

endmodule

// File: rtl/dcmd_te_gate.sv
module dcmd_te_gate #(
    parameter int DLY_W = 8,
    parameter int RAT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             arm,
    input  logic [1:0]       mode,
    input  logic             te_in,
    input  logic [DLY_W-1:0] delay,
    input  logic [RAT_W-1:0] ratio0,
    input  logic [RAT_W-1:0] ratio1,
    output logic             go
);
    localparam int CNT_W = DLY_W + 2 * ((1 << RAT_W) - 1);

    typedef struct packed {
        logic             s1;
        logic             s2;
        logic             prev;
        logic             wait_edge;
        logic             counting;
        logic [1:0]       mode;
        logic [CNT_W-1:0] cnt;
        logic             go;
    } gate_regs_t;

    gate_regs_t q, d;
    logic rise, fall, hit;
    logic [CNT_W-1:0] target;

    always_comb begin
        d      = q;
        d.s1   = te_in;
        d.s2   = q.s1;
        d.prev = q.s2;
        d.go   = 1'b0;
        rise   = q.s2 && !q.prev;
        fall   = !q.s2 && q.prev;
        hit    = (q.mode == 2'd1 && rise) || (q.mode == 2'd2 && fall);
        target = CNT_W'(delay) << ({1'b0, ratio0} + {1'b0, ratio1});
        if (clear) begin
            d.wait_edge = 1'b0;
            d.counting  = 1'b0;
        end else if (arm) begin
            d.mode = mode;
            if (mode == 2'd1 || mode == 2'd2) d.wait_edge = 1'b1;
            else                              d.go = 1'b1;
        end else if (q.wait_edge && hit) begin
            d.wait_edge = 1'b0;
            if (target == '0) begin
                d.go = 1'b1;
            end else begin
                d.counting = 1'b1;
                d.cnt      = CNT_W'(1);
            end
        end else if (q.counting) begin
            if (q.cnt >= target) begin
                d.go       = 1'b1;
                d.counting = 1'b0;
            end else begin
                d.cnt = q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign go = q.go;

    assert_go_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        go |=> !go);
    assert_wait_exclusive_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(q.wait_edge && q.counting));

endmodule

// File: rtl/dcmd_tx.sv
module dcmd_tx
    import dcmd_pkg::*;
#(
    parameter int FIFO_DEPTH = 8,
    parameter int DLY_W      = 8,
    parameter int RAT_W      = 3,
    localparam int LVL_W     = $clog2(FIFO_DEPTH) + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             lsb_first,
    input  logic             swap_en,
    input  logic [LVL_W-1:0] thresh,
    input  logic [DLY_W-1:0] te_delay,
    input  logic [RAT_W-1:0] ratio0,
    input  logic [RAT_W-1:0] ratio1,
    input  logic             te_in,
    input  logic             wr_valid,
    input  logic [31:0]      wr_data,
    output logic             sclk,
    output logic             sdo,
    output logic             cs_n,
    output logic             dc,
    output logic             done,
    output logic             fifo_low,
    output logic             fifo_ovf
);
    eng_regs_t q, d;

    logic [31:0]      head;
    logic             empty, pop, arm, go;
    logic [LVL_W-1:0] level;
    desc_t            hd;
    logic [1:0]       sel;

    dcmd_fifo #(.DEPTH(FIFO_DEPTH), .W(32)) u_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .flush (!enable),
        .push  (wr_valid && enable),
        .din   (wr_data),
        .pop   (pop),
        .dout  (head),
        .empty (empty),
        .level (level),
        .ovf   (fifo_ovf)
    );

    dcmd_te_gate #(.DLY_W(DLY_W), .RAT_W(RAT_W)) u_gate (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (!enable),
        .arm    (arm),
        .mode   (hd.te_mode),
        .te_in  (te_in),
        .delay  (te_delay),
        .ratio0 (ratio0),
        .ratio1 (ratio1),
        .go     (go)
    );

    function automatic logic [7:0] lane_byte(input logic [31:0] w, input logic [1:0] l);
        return w[{l, 3'b000} +: 8];
    endfunction

    always_comb begin
        d      = q;
        d.done = 1'b0;
        pop    = 1'b0;
        arm    = 1'b0;
        hd     = desc_decode(head);
        sel    = q.lane ^ (swap_en ? lane_mask(q.desc.unit) : 2'b00);
        case (q.st)
            ST_IDLE: begin
                if (enable && !empty) begin
                    pop    = 1'b1;
                    arm    = 1'b1;
                    d.desc = hd;
                    d.lane = 2'd0;
                    d.st   = ST_TE;
                end
            end
            ST_TE: begin
                if (go) d.st = ST_LOAD;
            end
            ST_LOAD: begin
                if (q.lane != 2'd0) begin
                    d.sh = lane_byte(q.word, sel);
                    d.st = ST_SHIFT;
                end else if (!empty) begin
                    pop    = 1'b1;
                    d.word = head;
                    d.sh   = lane_byte(head, sel);
                    d.st   = ST_SHIFT;
                end
                d.bitc  = 3'd0;
                d.phase = 1'b0;
            end
            default: begin
                if (!q.phase) begin
                    d.phase = 1'b1;
                end else begin
                    d.phase = 1'b0;
                    if (q.bitc != 3'd7) begin
                        d.bitc = q.bitc + 1'b1;
                    end else if (q.desc.len_m1 == '0) begin
                        d.st   = ST_IDLE;
                        d.done = q.desc.done_en;
                    end else begin
                        d.desc.len_m1 = q.desc.len_m1 - 1'b1;
                        d.lane        = q.lane + 1'b1;
                        d.st          = ST_LOAD;
                    end
                end
            end
        endcase
        if (!enable) begin
            d.st   = ST_IDLE;
            d.done = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign sclk     = (q.st == ST_SHIFT) && q.phase;
    assign sdo      = (q.st == ST_SHIFT) && q.sh[lsb_first ? q.bitc : 3'(3'd7 - q.bitc)];
    assign cs_n     = (q.st == ST_IDLE);
    assign dc       = q.desc.is_data;
    assign done     = q.done;
    assign fifo_low = (level <= thresh);

    assert_sclk_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> !sclk);
    assert_dc_stable_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_n && !$past(cs_n) |-> $stable(dc));
    assert_done_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> cs_n);
    assert_disable_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> cs_n && !done);

endmodule

// File: tb/dcmd_tx_bench.sv
module dcmd_tx_bench;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 8;
    localparam int LVL_W      = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic enable = 1'b0, lsb_first = 1'b0, swap_en = 1'b0;
    logic [LVL_W-1:0] thresh = 4'd7;
    logic [7:0] te_delay = 8'd0;
    logic [2:0] ratio0 = 3'd0, ratio1 = 3'd0;
    logic te_in = 1'b0, wr_valid = 1'b0;
    logic [31:0] wr_data = '0;
    logic sclk, sdo, cs_n, dc, done, fifo_low, fifo_ovf;

    dcmd_tx u_dcmd_tx (
        .clk(clk), .rst_n(rst_n), .enable(enable), .lsb_first(lsb_first),
        .swap_en(swap_en), .thresh(thresh), .te_delay(te_delay),
        .ratio0(ratio0), .ratio1(ratio1), .te_in(te_in),
        .wr_valid(wr_valid), .wr_data(wr_data), .sclk(sclk), .sdo(sdo),
        .cs_n(cs_n), .dc(dc), .done(done), .fifo_low(fifo_low), .fifo_ovf(fifo_ovf)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int nchk = 0, nfail = 0, cyc = 0;
    int ncap = 0, ndone = 0, mon_err = 0, nbit = 0;
    logic [7:0] cap_b [0:2047];
    logic       cap_dc[0:2047];
    logic [7:0] asm_b = '0;
    logic prev_sclk = 1'b0;
    logic watch_rise = 1'b0;
    int first_rise_cyc = 0;
    logic [31:0] pay [0:15];

    always @(posedge clk) cyc <= cyc + 1;

    // Monitor: sample at the falling core edge, away from updates.
    always @(negedge clk) begin
        if (sclk && cs_n) mon_err <= mon_err + 1;
        if (done) ndone <= ndone + 1;
        if (sclk && !prev_sclk) begin
            if (watch_rise) begin
                first_rise_cyc = cyc;
                watch_rise = 1'b0;
            end
            asm_b = lsb_first ? {sdo, asm_b[7:1]} : {asm_b[6:0], sdo};
            nbit = nbit + 1;
            if (nbit == 8) begin
                cap_b[ncap]  = asm_b;
                cap_dc[ncap] = dc;
                ncap = ncap + 1;
                nbit = 0;
            end
        end
        prev_sclk = sclk;
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        nfail++;
        $display("FAIL R1 watchdog: cycles %0d expected below %0d", cyc, 150000);
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    function automatic logic [31:0] bdesc(input int len, input bit isd, input bit den,
                                           input logic [1:0] fmt, input logic [1:0] te);
        logic [17:0] l = 18'(len - 1);
        return {1'b1, isd, den, fmt, 1'b0, te, 1'b0, 2'b00, 3'b000, l};
    endfunction

    function automatic logic [7:0] exp_byte(input logic [31:0] w, input int j,
                                            input logic [1:0] fmt, input bit sw);
        int m = 0;
        int lane;
        if (sw && fmt == 2'd1) m = 1;
        if (sw && fmt == 2'd2) m = 3;
        lane = j ^ m;
        return w[8*lane +: 8];
    endfunction

    task automatic push_word(input logic [31:0] w);
        do @(negedge clk); while (!fifo_low);
        wr_valid = 1'b1;
        wr_data  = w;
        @(negedge clk);
        wr_valid = 1'b0;
    endtask

    task automatic raw_write(input logic [31:0] w);
        @(negedge clk);
        wr_valid = 1'b1;
        wr_data  = w;
        @(negedge clk);
        wr_valid = 1'b0;
    endtask

    task automatic wait_idle(input int target);
        int n = 0;
        do begin @(negedge clk); n++; end
        while (!(ncap >= target && cs_n) && n < 20000);
        repeat (3) @(negedge clk);
    endtask

    task automatic fill_pay(input int nw);
        for (int w = 0; w < nw; w++) pay[w] = $urandom;
    endtask

    task automatic check_bytes(input int base, input int len, input bit isd,
                               input logic [1:0] fmt, input string req);
        int bad = -1;
        int bad_dc = -1;
        for (int i = 0; i < len; i++) begin
            if (bad < 0 && cap_b[base+i] !== exp_byte(pay[i/4], i % 4, fmt, swap_en)) bad = i;
            if (bad_dc < 0 && cap_dc[base+i] !== isd) bad_dc = i;
        end
        chk(bad < 0, req, "payload byte", (bad < 0) ? 0 : cap_b[base+bad],
            (bad < 0) ? 0 : exp_byte(pay[bad/4], bad % 4, fmt, swap_en));
        chk(bad_dc < 0, "R2", "dc level", (bad_dc < 0) ? isd : cap_dc[base+bad_dc], isd);
    endtask

    task automatic xfer(input int len, input bit isd, input logic [1:0] fmt,
                        input bit den, input string req);
        int base = ncap;
        int dbase;
        int nw = (len + 3) / 4;
        fill_pay(nw);
        dbase = ndone;
        push_word(bdesc(len, isd, den, fmt, 2'd0));
        for (int w = 0; w < nw; w++) push_word(pay[w]);
        wait_idle(base + len);
        chk(ncap - base == len && cs_n, "R1", "byte count", ncap - base, len);
        check_bytes(base, len, isd, fmt, req);
        chk(ndone - dbase == int'(den), "R8", "done pulses", ndone - dbase, den);
    endtask

    initial begin
        int base;
        int el;
        void'($urandom(32'h1a2b3c4d));
        repeat (4) @(negedge clk);
        chk(cs_n === 1'b1 && sclk === 1'b0 && done === 1'b0 && fifo_ovf === 1'b0,
            "R11", "reset outputs", {cs_n, sclk, done, fifo_ovf}, 4'b1000);
        rst_n = 1'b1;
        // R11: writes while disabled are ignored
        raw_write(32'hdeadbeef);
        repeat (3) @(negedge clk);
        chk(cs_n && ncap == 0, "R11", "disabled write ignored", ncap, 0);
        enable = 1'b1;
        repeat (2) @(negedge clk);
        chk(cs_n && ncap == 0, "R11", "no stale word after enable", ncap, 0);

        // Directed transfers
        xfer(1, 1'b0, 2'd0, 1'b1, "R1");
        xfer(5, 1'b1, 2'd0, 1'b1, "R4");
        xfer(7, 1'b1, 2'd0, 1'b0, "R4");
        lsb_first = 1'b1;
        xfer(6, 1'b1, 2'd0, 1'b1, "R3");
        lsb_first = 1'b0;
        swap_en = 1'b1;
        xfer(8, 1'b1, 2'd1, 1'b1, "R5");
        xfer(12, 1'b1, 2'd2, 1'b1, "R5");
        xfer(4, 1'b1, 2'd3, 1'b1, "R5");
        swap_en = 1'b0;

        // R6/R7: rising gate with delay, falling edge must be ignored
        te_delay = 8'd3; ratio0 = 3'd1; ratio1 = 3'd1;
        te_in = 1'b1;
        repeat (5) @(negedge clk);
        base = ncap;
        fill_pay(1);
        push_word(bdesc(4, 1'b1, 1'b0, 2'd0, 2'd1));
        push_word(pay[0]);
        repeat (20) @(negedge clk);
        te_in = 1'b0;
        repeat (40) @(negedge clk);
        chk(ncap == base && !cs_n && !sclk, "R6", "held on wrong edge", ncap - base, 0);
        watch_rise = 1'b1;
        te_in = 1'b1;
        el = cyc;
        wait (!watch_rise);
        el = first_rise_cyc - el;
        chk(el >= 12 && el <= 24, "R7", "edge-to-first-clock cycles", el, 12);
        wait_idle(base + 4);
        check_bytes(base, 4, 1'b1, 2'd0, "R6");

        // R6: falling gate, no delay
        te_delay = 8'd0;
        base = ncap;
        fill_pay(1);
        push_word(bdesc(4, 1'b0, 1'b0, 2'd0, 2'd2));
        push_word(pay[0]);
        repeat (30) @(negedge clk);
        chk(ncap == base, "R6", "held before falling edge", ncap - base, 0);
        te_in = 1'b0;
        wait_idle(base + 4);
        check_bytes(base, 4, 1'b0, 2'd0, "R6");

        // R12: payload starvation
        base = ncap;
        fill_pay(2);
        push_word(bdesc(8, 1'b1, 1'b1, 2'd0, 2'd0));
        push_word(pay[0]);
        repeat (80) @(negedge clk);
        chk(ncap - base == 4 && !cs_n && !sclk, "R12", "stall after first word", ncap - base, 4);
        push_word(pay[1]);
        wait_idle(base + 8);
        check_bytes(base, 8, 1'b1, 2'd0, "R12");

        // R9/R10: threshold and overflow with engine held on the gate
        thresh = 4'd3;
        base = ncap;
        fill_pay(9);
        push_word(bdesc(32, 1'b1, 1'b0, 2'd0, 2'd1));
        repeat (5) @(negedge clk);
        for (int w = 0; w < 3; w++) raw_write(pay[w]);
        chk(fifo_low === 1'b1, "R10", "low at level 3", fifo_low, 1);
        raw_write(pay[3]);
        chk(fifo_low === 1'b0, "R10", "not low at level 4", fifo_low, 0);
        for (int w = 4; w < 8; w++) raw_write(pay[w]);
        chk(fifo_ovf === 1'b0, "R9", "no overflow at full", fifo_ovf, 0);
        raw_write(pay[8]);
        chk(fifo_ovf === 1'b1, "R9", "overflow set", fifo_ovf, 1);
        te_in = 1'b1;
        wait_idle(base + 32);
        chk(ncap - base == 32, "R9", "bytes after overflow", ncap - base, 32);
        check_bytes(base, 32, 1'b1, 2'd0, "R9");
        chk(fifo_ovf === 1'b1, "R9", "overflow sticky", fifo_ovf, 1);
        thresh = 4'd7;
        te_in = 1'b0;

        // R11: flush with a word queued
        base = ncap;
        push_word(bdesc(8, 1'b1, 1'b0, 2'd0, 2'd1));
        push_word(32'h11223344);
        repeat (4) @(negedge clk);
        enable = 1'b0;
        @(negedge clk);
        @(negedge clk);
        chk(cs_n && !fifo_ovf && fifo_low, "R11", "flush state", {cs_n, fifo_ovf, fifo_low}, 3'b101);
        enable = 1'b1;
        te_in = 1'b1;
        repeat (10) @(negedge clk);
        chk(ncap == base && cs_n, "R11", "nothing sent after flush", ncap - base, 0);
        te_in = 1'b0;
        xfer(9, 1'b1, 2'd0, 1'b1, "R11");

        // Random mix
        for (int k = 0; k < 14; k++) begin
            lsb_first = 1'($urandom);
            swap_en   = 1'($urandom);
            xfer(1 + int'($urandom % 64), 1'($urandom), 2'($urandom % 3), 1'($urandom),
                 (k % 2 == 0) ? "R4" : "R5");
        end

        chk(mon_err == 0, "R3", "clock while deselected", mon_err, 0);
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

endmodule